// File: doc/BRIEF.md
# Sixteen-Entry Lookup Cache with Least-Recently-Used Victim Selection

This block is a small content-addressable store that sits beside a packet-processing engine. Its threads use it to share lookup results. Each of its sixteen slots holds a 32-bit key, a 4-bit status nibble, a valid flag and a lock flag. A search compares the presented key against every valid slot in a single cycle. One cycle later it reports whether the key was found, which slot holds it, and that slot's status.

When the key is absent, the same result names the slot that software should overwrite. That slot is the oldest one in a usage ordering maintained across all sixteen slots, skipping any slot whose lock flag is set. If every slot is locked, a separate flag reports that no replacement candidate exists. A load port writes a key and status into a chosen slot. A lock port sets or clears a slot's lock flag. There is no backing store behind the cache. Filling a slot after a miss is the caller's job.

Top module: `cam16_lru`

## Requirements
- R1: After reset, `res_valid` is 0, every slot is invalid so any search misses, no slot is locked, and the usage order runs from slot 0 (oldest) to slot 15 (newest).
- R2: A search presented with `lk_valid` high produces `res_valid` high exactly one clock later. `res_valid` is 0 in any cycle that follows a cycle without a search.
- R3: On a hit, `res_hit` is 1, `res_idx` is the matching slot number (4 bits, 0 to 15) and `res_status` is that slot's stored 4-bit status.
- R4: When several valid slots hold the searched key, the lowest-numbered slot is reported.
- R5: On a miss, `res_hit` is 0, `res_status` is 0, and `res_idx` is the oldest unlocked slot in the usage order.
- R6: A load, or a search that hits, moves the touched slot to the newest position. When a load and a search occur in the same cycle, the search compares against the contents before the load, and only the load's slot is moved.
- R7: A locked slot is never reported as a miss victim. It still hits on a search and can still be loaded.
- R8: On a miss with all sixteen slots locked, `res_novictim` is 1 and `res_idx` is 0. `res_novictim` is 0 on every hit.
- R9: A load with `wr_valid` high stores `wr_tag` and `wr_status` into slot `wr_idx` and marks it valid. The new contents are visible to searches from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_valid | input | 1 | Search request |
| lk_key | input | 32 | Key to search for |
| wr_valid | input | 1 | Load request |
| wr_idx | input | 4 | Slot to load |
| wr_tag | input | 32 | Key written into the slot |
| wr_status | input | 4 | Status written into the slot |
| lock_en | input | 1 | Lock flag update request |
| lock_idx | input | 4 | Slot whose lock flag is updated |
| lock_val | input | 1 | New lock flag value (1 = locked) |
| res_valid | output | 1 | Search result valid |
| res_hit | output | 1 | Key found |
| res_idx | output | 4 | Matching slot on hit, victim slot on miss |
| res_status | output | 4 | Status of the matching slot, 0 on miss |
| res_novictim | output | 1 | Miss with every slot locked |

## Verification
The hardest case to reach is a miss whose victim is forced deep into the usage order. That requires an ordering that differs from the reset order and several of the oldest slots locked. The bench builds this ordering on purpose. It loads slots out of numeric order and hits on a duplicated key. Then it locks the oldest slots one by one, until only a slot in the middle of the order is eligible. It also covers the fully locked case and the cycle in which a load and a search collide on the same key.

// File: rtl/cam_pkg.sv
package cam_pkg;
    parameter int unsigned CAM_DEF_ENTRIES = 16;
    parameter int unsigned CAM_DEF_TAG_W   = 32;
    parameter int unsigned CAM_DEF_STAT_W  = 4;
endpackage

// File: rtl/cam_match.sv
// Parallel key compare with lowest-index priority.
module cam_match #(
    parameter int unsigned ENTRIES = 16,
    parameter int unsigned TAG_W   = 32,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic [TAG_W-1:0]                key,
    input  logic [ENTRIES-1:0][TAG_W-1:0]   tags,
    input  logic [ENTRIES-1:0]              vld,
    output logic                            hit,
    output logic [IDX_W-1:0]                idx
);
    logic [ENTRIES-1:0] eq;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign eq[g] = vld[g] && (tags[g] == key);
    end

    always_comb begin
        hit = |eq;
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (eq[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/cam_lru_order.sv
// Next usage order after moving one slot to the newest position.
// Position 0 holds the oldest slot number.
module cam_lru_order #(
    parameter int unsigned ENTRIES = 16,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0][IDX_W-1:0] ord_q,
    input  logic [IDX_W-1:0]              touch_idx,
    output logic [ENTRIES-1:0][IDX_W-1:0] ord_d
);
    logic [ENTRIES-1:0] at_or_above;

    always_comb begin
        logic seen;
        seen = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            seen = seen | (ord_q[i] == touch_idx);
            at_or_above[i] = seen;
        end
        for (int i = 0; i < ENTRIES - 1; i++) begin
            ord_d[i] = at_or_above[i] ? ord_q[i+1] : ord_q[i];
        end
        ord_d[ENTRIES-1] = touch_idx;
    end
endmodule

// File: rtl/cam_victim.sv
// Oldest unlocked slot in the usage order.
module cam_victim #(
    parameter int unsigned ENTRIES = 16,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0][IDX_W-1:0] ord_q,
    input  logic [ENTRIES-1:0]            lock,
    output logic [IDX_W-1:0]              victim,
    output logic                          none
);
    always_comb begin
        victim = '0;
        none   = &lock;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!lock[ord_q[i]]) victim = ord_q[i];
        end
    end
endmodule

// File: rtl/cam16_lru.sv
module cam16_lru #(
    parameter int unsigned ENTRIES = cam_pkg::CAM_DEF_ENTRIES,
    parameter int unsigned TAG_W   = cam_pkg::CAM_DEF_TAG_W,
    parameter int unsigned STAT_W  = cam_pkg::CAM_DEF_STAT_W,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [TAG_W-1:0]  lk_key,
    input  logic              wr_valid,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [STAT_W-1:0] wr_status,
    input  logic              lock_en,
    input  logic [IDX_W-1:0]  lock_idx,
    input  logic              lock_val,
    output logic              res_valid,
    output logic              res_hit,
    output logic [IDX_W-1:0]  res_idx,
    output logic [STAT_W-1:0] res_status,
    output logic              res_novictim
);
    typedef struct packed {
        logic [ENTRIES-1:0][TAG_W-1:0]  tag;
        logic [ENTRIES-1:0][STAT_W-1:0] stat;
        logic [ENTRIES-1:0]             vld;
        logic [ENTRIES-1:0]             lock;
        logic [ENTRIES-1:0][IDX_W-1:0]  ord;
        logic                           r_valid;
        logic                           r_hit;
        logic                           r_nov;
        logic [IDX_W-1:0]               r_idx;
        logic [STAT_W-1:0]              r_stat;
    } state_t;

    function automatic state_t reset_state();
        state_t s;
        s = '0;
        for (int i = 0; i < ENTRIES; i++) s.ord[i] = IDX_W'(i);
        return s;
    endfunction

    state_t s_d, s_q;

    logic              m_hit;
    logic [IDX_W-1:0]  m_idx;
    logic [IDX_W-1:0]  vic_idx;
    logic              vic_none;
    logic [IDX_W-1:0]  touch_idx;
    logic [ENTRIES-1:0][IDX_W-1:0] ord_touched;

    cam_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_match (
        .key  (lk_key),
        .tags (s_q.tag),
        .vld  (s_q.vld),
        .hit  (m_hit),
        .idx  (m_idx)
    );

    cam_victim #(.ENTRIES(ENTRIES)) u_victim (
        .ord_q  (s_q.ord),
        .lock   (s_q.lock),
        .victim (vic_idx),
        .none   (vic_none)
    );

    assign touch_idx = wr_valid ? wr_idx : m_idx;

    cam_lru_order #(.ENTRIES(ENTRIES)) u_order (
        .ord_q     (s_q.ord),
        .touch_idx (touch_idx),
        .ord_d     (ord_touched)
    );

    always_comb begin
        s_d = s_q;

        s_d.r_valid = lk_valid;
        s_d.r_hit   = 1'b0;
        s_d.r_nov   = 1'b0;
        s_d.r_idx   = '0;
        s_d.r_stat  = '0;
        if (lk_valid) begin
            if (m_hit) begin
                s_d.r_hit  = 1'b1;
                s_d.r_idx  = m_idx;
                s_d.r_stat = s_q.stat[m_idx];
            end else begin
                s_d.r_idx  = vic_none ? '0 : vic_idx;
                s_d.r_nov  = vic_none;
            end
        end

        if (wr_valid) begin
            s_d.tag[wr_idx]  = wr_tag;
            s_d.stat[wr_idx] = wr_status;
            s_d.vld[wr_idx]  = 1'b1;
        end

        if (lock_en) s_d.lock[lock_idx] = lock_val;

        if (wr_valid || (lk_valid && m_hit)) s_d.ord = ord_touched;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= reset_state();
        else        s_q <= s_d;
    end

    assign res_valid    = s_q.r_valid;
    assign res_hit      = s_q.r_hit;
    assign res_idx      = s_q.r_idx;
    assign res_status   = s_q.r_stat;
    assign res_novictim = s_q.r_nov;
endmodule

// File: rtl/cam16_lru_chk.sv
module cam16_lru_chk #(
    parameter int unsigned ENTRIES = 16,
    parameter int unsigned TAG_W   = 32,
    parameter int unsigned STAT_W  = 4,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic [TAG_W-1:0]  lk_key,
    input logic              wr_valid,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [TAG_W-1:0]  wr_tag,
    input logic              lock_en,
    input logic [IDX_W-1:0]  lock_idx,
    input logic              lock_val,
    input logic              res_valid,
    input logic              res_hit,
    input logic [IDX_W-1:0]  res_idx,
    input logic [STAT_W-1:0] res_status,
    input logic              res_novictim
);
    logic [ENTRIES-1:0] lock_shadow_q;
    logic [ENTRIES-1:0] lock_snap_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_shadow_q <= '0;
            lock_snap_q   <= '0;
        end else begin
            if (lock_en) lock_shadow_q[lock_idx] <= lock_val;
            lock_snap_q <= lock_shadow_q;
        end
    end

    // R2
    result_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);

    // R2
    no_spurious_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !res_valid);

    // R5
    miss_status_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (res_status == '0));

    // R7
    victim_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit && !res_novictim) |-> !lock_snap_q[res_idx]);

    // R8
    novictim_all_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_novictim |-> (res_valid && !res_hit && (&lock_snap_q) && res_idx == '0));

    // R9
    load_then_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && $past(wr_valid) && lk_key == $past(wr_tag)) |=> res_hit);
endmodule

bind cam16_lru cam16_lru_chk #(
    .ENTRIES(ENTRIES), .TAG_W(TAG_W), .STAT_W(STAT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_key(lk_key),
    .wr_valid(wr_valid), .wr_idx(wr_idx), .wr_tag(wr_tag),
    .lock_en(lock_en), .lock_idx(lock_idx), .lock_val(lock_val),
    .res_valid(res_valid), .res_hit(res_hit), .res_idx(res_idx),
    .res_status(res_status), .res_novictim(res_novictim)
);

// File: tb/cam16_lru_tb.sv
module cam16_lru_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_key = '0;
    logic        wr_valid = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [31:0] wr_tag = '0;
    logic [3:0]  wr_status = '0;
    logic        lock_en = 1'b0;
    logic [3:0]  lock_idx = '0;
    logic        lock_val = 1'b0;
    logic        res_valid, res_hit, res_novictim;
    logic [3:0]  res_idx, res_status;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    cam16_lru u_dut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_key(lk_key),
        .wr_valid(wr_valid), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_status(wr_status),
        .lock_en(lock_en), .lock_idx(lock_idx), .lock_val(lock_val),
        .res_valid(res_valid), .res_hit(res_hit), .res_idx(res_idx),
        .res_status(res_status), .res_novictim(res_novictim)
    );

    localparam logic [31:0] KA = 32'h1111_1111;
    localparam logic [31:0] KB = 32'h2222_2222;
    localparam logic [31:0] KC = 32'h3333_3333;
    localparam logic [31:0] KD = 32'h4444_4444;
    localparam logic [31:0] KE = 32'h5555_5555;
    localparam logic [31:0] KF = 32'h6666_6666;
    localparam logic [31:0] KG = 32'h7777_7777;

    // {op(2: 0 search, 1 load), idx(4), tag(32), status(4), exp_hit(1), exp_idx(4), exp_status(4)}
    localparam int NV = 10;
    localparam logic [50:0] VECS [0:NV-1] = '{
        {2'd0, 4'd0, KA, 4'd0, 1'b0, 4'd0, 4'd0},  // R1/R5 miss, victim 0
        {2'd1, 4'd0, KA, 4'd3, 1'b0, 4'd0, 4'd0},  // R9 load slot 0
        {2'd0, 4'd0, KA, 4'd0, 1'b1, 4'd0, 4'd3},  // R3 hit
        {2'd0, 4'd0, KB, 4'd0, 1'b0, 4'd1, 4'd0},  // R6 victim 1
        {2'd1, 4'd1, KB, 4'd5, 1'b0, 4'd0, 4'd0},
        {2'd1, 4'd5, KC, 4'd9, 1'b0, 4'd0, 4'd0},
        {2'd0, 4'd0, KD, 4'd0, 1'b0, 4'd2, 4'd0},  // R6 victim 2
        {2'd1, 4'd2, KA, 4'd7, 1'b0, 4'd0, 4'd0},  // duplicate key
        {2'd0, 4'd0, KA, 4'd0, 1'b1, 4'd0, 4'd3},  // R4 lowest wins
        {2'd0, 4'd0, KE, 4'd0, 1'b0, 4'd3, 4'd0}   // R5 victim 3
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic search(input logic [31:0] k, input string req,
                          input bit eh, input int ei, input int es, input bit en);
        @(negedge clk);
        lk_valid = 1'b1; lk_key = k;
        @(posedge clk);
        @(negedge clk);
        lk_valid = 1'b0;
        chk(res_valid == 1'b1, {req, " valid"}, int'(res_valid), 1);
        chk(res_hit == eh, {req, " hit"}, int'(res_hit), int'(eh));
        chk(res_idx == 4'(ei), {req, " idx"}, int'(res_idx), ei);
        chk(res_status == 4'(es), {req, " status"}, int'(res_status), es);
        chk(res_novictim == en, {req, " novictim"}, int'(res_novictim), int'(en));
    endtask

    task automatic load(input int i, input logic [31:0] t, input int s);
        @(negedge clk);
        wr_valid = 1'b1; wr_idx = 4'(i); wr_tag = t; wr_status = 4'(s);
        @(posedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
        chk(res_valid == 1'b0, "R2 no result after load", int'(res_valid), 0);
    endtask

    task automatic set_lock(input int i, input bit v);
        @(negedge clk);
        lock_en = 1'b1; lock_idx = 4'(i); lock_val = v;
        @(posedge clk);
        @(negedge clk);
        lock_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(res_valid == 1'b0, "R1 reset res_valid", int'(res_valid), 0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            logic [50:0] e;
            e = VECS[v];
            if (e[50:49] == 2'd1) load(int'(e[48:45]), e[44:13], int'(e[12:9]));
            else search(e[44:13], "R3/R5 table", e[8], int'(e[7:4]), int'(e[3:0]), 1'b0);
        end

        // Usage order now 3,4,6..15,1,5,2,0
        set_lock(3, 1'b1);
        set_lock(4, 1'b1);
        search(KE, "R7 skip locked", 1'b0, 6, 0, 1'b0);
        set_lock(5, 1'b1);
        search(KC, "R7 locked hit", 1'b1, 5, 9, 1'b0);
        for (int i = 0; i < 16; i++) set_lock(i, 1'b1);
        search(KE, "R8 all locked", 1'b0, 0, 0, 1'b1);
        set_lock(9, 1'b1 ^ 1'b1);
        search(KE, "R5 deep victim", 1'b0, 9, 0, 1'b0);

        load(0, KF, 1);
        search(KA, "R4 R9 overwrite", 1'b1, 2, 7, 1'b0);
        search(KF, "R9 locked load", 1'b1, 0, 1, 1'b0);

        // Same-cycle load and search on the same key
        @(negedge clk);
        wr_valid = 1'b1; wr_idx = 4'd9; wr_tag = KG; wr_status = 4'd2;
        lk_valid = 1'b1; lk_key = KG;
        @(posedge clk);
        @(negedge clk);
        wr_valid = 1'b0; lk_valid = 1'b0;
        chk(res_hit == 1'b0, "R6 search sees old contents", int'(res_hit), 0);
        chk(res_idx == 4'd9, "R6 victim in collision", int'(res_idx), 9);
        search(KG, "R6 load visible", 1'b1, 9, 2, 1'b0);

        for (int i = 0; i < 16; i++) set_lock(i, 1'b0);
        search(KE, "R6 order oldest", 1'b0, 3, 0, 1'b0);
        set_lock(3, 1'b1);
        search(KE, "R6 order second", 1'b0, 4, 0, 1'b0);

        // Reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(res_valid == 1'b0, "R1 reset clears result", int'(res_valid), 0);
        rst_n = 1'b1;
        search(KG, "R1 tags invalid", 1'b0, 0, 0, 1'b0);
        load(0, KB, 4);
        search(KE, "R1 reset order", 1'b0, 1, 0, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule